// File: doc/BRIEF.md
# Make-Before-Break Wiper Tap Selector

The block drives the switch enables of a resistor-string wiper. It takes a 7-bit tap code and produces 128 enable lines, one for each tap. Code 0 is the tap beside the low end of the string and code 127 is the tap beside the high end. A larger code always selects a tap nearer the high end. When the system is settled, exactly one enable is high, and its index equals the code.

When the code changes, the block does not simply swap one enable for another. It first turns on the enable of the new tap while the enable of the old tap stays on. This overlap lasts a fixed number of clock cycles, and only then is the old enable turned off. The wiper therefore never floats.

A code change that arrives during an overlap is not applied at once. The current overlap runs to its end. The block then compares the latest code with its target and, if they differ, starts a new overlap from that target toward the latest code. A busy output is high for as long as an overlap lasts. After reset the wiper sits at mid-scale, tap 64.

Top module: `mbb_tap_select`

## Requirements
- R1: While reset is asserted and after it is released with the code held at 64, only tap_en_o[64] is high and busy_o is low.
- R2: At steady state exactly one enable is high and its bit index equals the code: code 0 gives bit 0 (low end) and code 127 gives bit 127 (high end). Both extremes are reachable, and the position never wraps.
- R3: A code that differs from the target while the block is idle starts an overlap one clock later. From then on, both the old and the new enable are high and busy_o is high.
- R4: An overlap lasts OVERLAP clock cycles (3 by default). After it, only the new enable is high and busy_o is low.
- R5: In every cycle after reset, one or two enables are high, never zero and never more than two.
- R6: Code changes during an overlap do not alter the enables until that overlap ends. If the latest code then differs from the target, a new overlap of OVERLAP cycles starts at once from the old target to the latest code. Intermediate codes are never selected. If the latest code equals the target, the block goes idle.
- R7: Applying a code equal to the current target starts no overlap, and the enables stay unchanged.
- R8: busy_o is high exactly in the cycles in which two enables are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| code_i | input | 7 | Requested tap code |
| tap_en_o | output | 128 | One enable per tap, bit n for tap n |
| busy_o | output | 1 | High while an overlap is in progress |

## Verification
The assertions assume two things about the inputs: that the tap code is stable at each rising edge, and that reset is held for at least one edge before any check starts. The bench meets both by changing the code only on falling edges and by holding it at the mid-scale value while reset is asserted, so no overlap is launched when reset is released. No other constraint is placed on the code. The bench changes it at any point during an overlap, including back to the current target, because the block must then behave by the rule in R6.

// File: rtl/mbb_pkg.sv
package mbb_pkg;

    localparam int DEF_CODE_W  = 7;
    localparam int DEF_OVERLAP = 3;

    typedef enum logic {
        PH_IDLE    = 1'b0,
        PH_OVERLAP = 1'b1
    } phase_e;

endpackage

// File: rtl/mbb_onehot.sv
module mbb_onehot #(
    parameter int CODE_W = 7,
    localparam int NTAPS = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              en_i,
    output logic [NTAPS-1:0]  onehot_o
);

    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        assign onehot_o[g] = en_i && (code_i == CODE_W'(g));
    end

endmodule

// File: rtl/mbb_tap_seq.sv
module mbb_tap_seq
    import mbb_pkg::*;
#(
    parameter int CODE_W    = 7,
    parameter int OVERLAP   = 3,
    parameter int RESET_TAP = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] cur_o,
    output logic [CODE_W-1:0] old_o,
    output logic              busy_o
);

    localparam int CNT_W = (OVERLAP > 1) ? $clog2(OVERLAP) : 1;
    localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(RESET_TAP);
    localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(OVERLAP - 1);

    typedef struct packed {
        logic [CODE_W-1:0] cur;
        logic [CODE_W-1:0] old;
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic launch;

    always_comb begin
        s_d    = s_q;
        launch = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (code_i != s_q.cur) begin
                    launch = 1'b1;
                end
            end
            PH_OVERLAP: begin
                if (s_q.cnt == '0) begin
                    if (code_i != s_q.cur) begin
                        launch = 1'b1;
                    end else begin
                        s_d.phase = PH_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
        if (launch) begin
            s_d.old   = s_q.cur;
            s_d.cur   = code_i;
            s_d.phase = PH_OVERLAP;
            s_d.cnt   = CNT_LOAD;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.cur   <= RST_CODE;
            s_q.old   <= RST_CODE;
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_o  = s_q.cur;
    assign old_o  = s_q.old;
    assign busy_o = (s_q.phase == PH_OVERLAP);

    // R3: an idle change launches an overlap from the old target to the sampled code
    assert_launch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && code_i != cur_o) |=>
            (busy_o && cur_o == $past(code_i) && old_o == $past(cur_o)));

    // R6: the target holds while an overlap still has cycles left
    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && s_q.cnt != '0) |=> $stable(cur_o));

    // R4: leaving an overlap keeps the target it reached
    assert_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $stable(cur_o));

endmodule

// File: rtl/mbb_tap_select.sv
module mbb_tap_select
    import mbb_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int OVERLAP   = DEF_OVERLAP,
    parameter int RESET_TAP = (1 << DEF_CODE_W) / 2,
    localparam int NTAPS    = 1 << CODE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    output logic [NTAPS-1:0]  tap_en_o,
    output logic              busy_o
);

    logic [CODE_W-1:0] cur_code, old_code;
    logic              busy;
    logic [NTAPS-1:0]  new_en, prev_en;

    mbb_tap_seq #(
        .CODE_W    (CODE_W),
        .OVERLAP   (OVERLAP),
        .RESET_TAP (RESET_TAP)
    ) u_seq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .code_i (code_i),
        .cur_o  (cur_code),
        .old_o  (old_code),
        .busy_o (busy)
    );

    mbb_onehot #(.CODE_W(CODE_W)) u_dec_new (
        .code_i   (cur_code),
        .en_i     (1'b1),
        .onehot_o (new_en)
    );

    mbb_onehot #(.CODE_W(CODE_W)) u_dec_old (
        .code_i   (old_code),
        .en_i     (busy),
        .onehot_o (prev_en)
    );

    assign tap_en_o = new_en | prev_en;
    assign busy_o   = busy;

    // R5: never a floating wiper and never more than two closed switches
    assert_enable_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(tap_en_o) == 1 || $countones(tap_en_o) == 2));

    // R8: busy marks exactly the two-enable cycles
    assert_busy_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o == ($countones(tap_en_o) == 2));

    // R3: the enable that was on before an overlap is still on when it begins
    assert_make_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> ((tap_en_o & $past(tap_en_o)) != '0));

endmodule

// File: tb/mbb_tap_select_test.sv
module mbb_tap_select_test;

    localparam int CW  = 7;
    localparam int NT  = 128;
    localparam int OVL = 3;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] code  = 7'd64;
    logic [NT-1:0] en;
    logic          busy;

    int checks  = 0;
    int errors  = 0;
    int bad_cnt = 0;
    int cur_m   = 64;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    mbb_tap_select #(.CODE_W(CW), .OVERLAP(OVL), .RESET_TAP(64)) uut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .code_i   (code),
        .tap_en_o (en),
        .busy_o   (busy)
    );

    function automatic logic [NT-1:0] oh(int t);
        logic [NT-1:0] v;
        v    = '0;
        v[t] = 1'b1;
        return v;
    endfunction

    task automatic check(bit ok, string tag, logic [NT-1:0] act, logic [NT-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_state(string tag, logic [NT-1:0] exp_en, logic exp_busy);
        check(en == exp_en, tag, en, exp_en);
        check(busy == exp_busy, {tag, " busy"}, NT'(busy), NT'(exp_busy));
    endtask

    task automatic negs(int n);
        repeat (n) @(negedge clk);
    endtask

    // R5 monitor: count any cycle with zero or more than two enables
    always @(negedge clk) begin
        if (rst_n && !($countones(en) == 1 || $countones(en) == 2)) bad_cnt++;
    end

    task automatic move(int t);
        code = CW'(t);
        if (t == cur_m) begin
            negs(2);
            check_state("R7 same code", oh(cur_m), 1'b0);
        end else begin
            negs(1);
            check_state("R3 overlap start", oh(cur_m) | oh(t), 1'b1);
            negs(OVL - 1);
            check_state("R4 overlap last cycle", oh(cur_m) | oh(t), 1'b1);
            negs(1);
            check_state("R2 R4 settled", oh(t), 1'b0);
            cur_m = t;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        negs(3);
        check_state("R1 in reset", oh(64), 1'b0);
        rst_n = 1'b1;
        negs(2);
        check_state("R1 after reset", oh(64), 1'b0);

        move(64);
        for (int t = 0; t < NT; t++) move(t);
        move(0);
        move(127);
        move(127);
        for (int i = 0; i < NT; i++) move((i * 37 + 5) % NT);

        // R6: changes during an overlap, chained overlap to the latest code
        move(50);
        code = 7'd60;
        negs(1);
        check_state("R6 first overlap", oh(50) | oh(60), 1'b1);
        code = 7'd70;
        negs(1);
        code = 7'd90;
        negs(1);
        check_state("R6 intermediate ignored", oh(50) | oh(60), 1'b1);
        negs(1);
        check_state("R6 chained overlap", oh(60) | oh(90), 1'b1);
        negs(OVL - 1);
        check_state("R6 chained last cycle", oh(60) | oh(90), 1'b1);
        negs(1);
        check_state("R6 chained settled", oh(90), 1'b0);
        cur_m = 90;

        // R6: code returns to the target before the overlap ends
        code = 7'd20;
        negs(1);
        check_state("R6 second overlap", oh(90) | oh(20), 1'b1);
        code = 7'd55;
        negs(1);
        code = 7'd20;
        negs(1);
        check_state("R6 returning code held", oh(90) | oh(20), 1'b1);
        negs(1);
        check_state("R6 no new overlap", oh(20), 1'b0);
        cur_m = 20;

        check(bad_cnt == 0, "R5 enable count", NT'(bad_cnt), '0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

endmodule